// File: doc/BRIEF.md
# Two-Level Lookahead Adder

A combinational 16-bit binary adder for datapaths where the carry path must stay short. The operands are cut into four 4-bit groups. Each group works out per-bit generate and propagate terms. From these it forms its own internal carries as flat sums of products, plus a group-level generate and propagate pair. A second lookahead stage of the same shape takes the four group pairs and the incoming carry. It produces the carry into every group, so carries never ripple from one group to the next.

The adder also exports a whole-word generate and propagate pair, so a wider adder can place a third lookahead level over several of these blocks. There is no clock and no state: every output is a pure function of the present inputs.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + ci_i`, taken as unsigned numbers.
- R2: `co_o` equals bit 16 of the unsigned sum `a_i + b_i + ci_i`.
- R3: `grp_g_o` is 1 exactly when `a_i + b_i` alone, with no carry-in, overflows 16 bits.
- R4: `grp_p_o` is 1 exactly when every bit position has at least one operand bit set, that is `(a_i | b_i) == 16'hFFFF`.
- R5: When `grp_g_o` is 1, `co_o` is 1 for both values of `ci_i`.
- R6: `co_o` equals `grp_g_o | (grp_p_o & ci_i)` for all inputs.
- R7: With both operands all ones, a carry-in of 1 gives `sum_o = 16'hFFFF` and `co_o = 1`. Adding 1 to an all-ones operand (the other operand zero, `ci_i = 1`) gives `sum_o = 0` and `co_o = 1`.
- R8: With both operands zero, `sum_o` equals `ci_i` and `co_o`, `grp_g_o` and `grp_p_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| ci_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| co_o | output | 1 | Carry out of bit 15 |
| grp_g_o | output | 1 | Whole-word generate |
| grp_p_o | output | 1 | Whole-word propagate |

## Verification
Zero operands with each carry-in value show that the carry-in reaches only bit 0 and that the generate and propagate flags stay low. An all-ones operand plus one drives a carry through every group and so exercises each second-level product term. Alternating patterns such as 0xAAAA with 0x5555 set propagate in every bit with no generate, which separates the `grp_p_o` path from the `grp_g_o` path and shows whether the carry-in alone decides `co_o`. Values that sit on a group boundary, such as 0x000F+1, 0x0FFF+1 and 0x8000+0x8000, together with random operands, catch a wrong carry into any one group or a wrong group-level term.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GROUP_W    = 4;
  localparam int unsigned NUM_GROUPS = 4;
  localparam int unsigned DATA_W     = GROUP_W * NUM_GROUPS;
endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
// c_o[k] is the carry into position k (c_o[0] is the incoming carry).
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N-1:0] c_o,
  output logic         g_o,
  output logic         p_o
);

  always_comb begin
    c_o[0] = c_i;
    for (int k = 1; k < int'(N); k++) begin
      logic acc;
      logic term;
      // term carried in from c_i through p[0..k-1]
      term = c_i;
      for (int m = 0; m < k; m++) term = term & p_i[m];
      acc = term;
      // term generated at j, propagated through p[j+1..k-1]
      for (int j = 0; j < k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m < k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      c_o[k] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < int'(N); j++) begin
      term = g_i[j];
      for (int m = j + 1; m < int'(N); m++) term = term & p_i[m];
      acc = acc | term;
    end
    g_o = acc;
  end

  assign p_o = &p_i;

endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit g/p, group carries, group G/P and sum.
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         g_o,
  output logic         p_o
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_x;
  logic [W-1:0] bit_c;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;
  // propagate uses OR, so the half-sum needs its own XOR
  assign bit_x = a_i ^ b_i;

  cla_lookahead #(.N(W)) i_look (
    .g_i (bit_g),
    .p_i (bit_p),
    .c_i (c_i),
    .c_o (bit_c),
    .g_o (g_o),
    .p_o (p_o)
  );

  assign sum_o = bit_x ^ bit_c;

endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
  import cla_pkg::*;
#(
  parameter int unsigned GW = GROUP_W,
  parameter int unsigned NG = NUM_GROUPS,
  localparam int unsigned DW = GW * NG
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o,
  output logic          grp_g_o,
  output logic          grp_p_o
);

  logic [NG-1:0] blk_g;
  logic [NG-1:0] blk_p;
  logic [NG-1:0] blk_c;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    cla_group #(.W(GW)) i_grp (
      .a_i   (a_i[gi*GW +: GW]),
      .b_i   (b_i[gi*GW +: GW]),
      .c_i   (blk_c[gi]),
      .sum_o (sum_o[gi*GW +: GW]),
      .g_o   (blk_g[gi]),
      .p_o   (blk_p[gi])
    );
  end

  // second level: carry into each group from group G/P
  cla_lookahead #(.N(NG)) i_top_look (
    .g_i (blk_g),
    .p_i (blk_p),
    .c_i (ci_i),
    .c_o (blk_c),
    .g_o (grp_g_o),
    .p_o (grp_p_o)
  );

  assign co_o = grp_g_o | (grp_p_o & ci_i);

endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
  parameter int unsigned DW = 16
) (
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          ci_i,
  input logic [DW-1:0] sum_o,
  input logic          co_o,
  input logic          grp_g_o,
  input logic          grp_p_o
);

  logic [DW:0] ref_full;
  logic [DW:0] ref_nocin;

  always_comb begin
    ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci_i};
    ref_nocin = {1'b0, a_i} + {1'b0, b_i};
    a_r1_sum: assert ({co_o, sum_o} == ref_full || $isunknown({a_i, b_i, ci_i}))
      else $error("R1/R2 sum or carry-out wrong");
    a_r3_gen: assert (grp_g_o == ref_nocin[DW] || $isunknown({a_i, b_i}))
      else $error("R3 group generate wrong");
    a_r4_prop: assert (grp_p_o == (&(a_i | b_i)) || $isunknown({a_i, b_i}))
      else $error("R4 group propagate wrong");
    a_r5_gen_forces_co: assert (!grp_g_o || co_o || $isunknown({a_i, b_i, ci_i}))
      else $error("R5 generate without carry-out");
    a_r6_co_from_gp: assert (co_o == (grp_g_o | (grp_p_o & ci_i)) || $isunknown({a_i, b_i, ci_i}))
      else $error("R6 carry-out disagrees with G/P");
  end

endmodule

bind cla2_adder cla2_adder_chk #(.DW(DW)) i_cla2_adder_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .ci_i    (ci_i),
  .sum_o   (sum_o),
  .co_o    (co_o),
  .grp_g_o (grp_g_o),
  .grp_p_o (grp_p_o)
);

// File: tb/test_cla2_adder.sv
module test_cla2_adder;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic [DW-1:0] a_i = '0;
  logic [DW-1:0] b_i = '0;
  logic          ci_i = 1'b0;
  logic [DW-1:0] sum_o;
  logic          co_o;
  logic          grp_g_o;
  logic          grp_p_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct packed {
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic          ci;
    logic [DW-1:0] sum;
    logic          co;
    logic          g;
    logic          p;
  } item_t;

  item_t exp_q[$];

  always #5 clk = ~clk;

  cla2_adder i_cla2_adder (
    .a_i     (a_i),
    .b_i     (b_i),
    .ci_i    (ci_i),
    .sum_o   (sum_o),
    .co_o    (co_o),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic ci);
    item_t it;
    logic [DW:0] full;
    logic [DW:0] nocin;
    full  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
    nocin = {1'b0, a} + {1'b0, b};
    it.a = a; it.b = b; it.ci = ci;
    it.sum = full[DW-1:0];
    it.co  = full[DW];
    it.g   = nocin[DW];
    it.p   = ((a | b) == {DW{1'b1}});
    @(posedge clk);
    a_i  = a;
    b_i  = b;
    ci_i = ci;
    exp_q.push_back(it);
  endtask

  task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp, input item_t it);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h", tag, it.a, it.b, it.ci, act, exp);
    end
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      cmp("R1 sum",  sum_o, it.sum, it);
      cmp("R2 co",   {{(DW-1){1'b0}}, co_o}, {{(DW-1){1'b0}}, it.co}, it);
      cmp("R3 gen",  {{(DW-1){1'b0}}, grp_g_o}, {{(DW-1){1'b0}}, it.g}, it);
      cmp("R4 prop", {{(DW-1){1'b0}}, grp_p_o}, {{(DW-1){1'b0}}, it.p}, it);
      if (it.g) cmp("R5 gen forces co", {{(DW-1){1'b0}}, co_o}, {{(DW-1){1'b0}}, 1'b1}, it);
      cmp("R6 co from G/P", {{(DW-1){1'b0}}, co_o},
          {{(DW-1){1'b0}}, grp_g_o | (grp_p_o & it.ci)}, it);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: zero operands, both carry-in values
    drive('0, '0, 1'b0);
    drive('0, '0, 1'b1);
    // R7: all ones through every group
    drive(16'hFFFF, 16'h0000, 1'b1);
    drive(16'hFFFF, 16'hFFFF, 1'b1);
    drive(16'hFFFF, 16'hFFFF, 1'b0);
    drive(16'hFFFF, 16'h0001, 1'b0);
    // propagate everywhere, no generate: carry-in alone decides co (R4, R6)
    drive(16'hAAAA, 16'h5555, 1'b0);
    drive(16'hAAAA, 16'h5555, 1'b1);
    drive(16'hAAAA, 16'hAAAA, 1'b0);
    drive(16'h5555, 16'h5555, 1'b1);
    // group boundaries
    drive(16'h000F, 16'h0001, 1'b0);
    drive(16'h00FF, 16'h0000, 1'b1);
    drive(16'h0FFF, 16'h0001, 1'b0);
    drive(16'h8000, 16'h8000, 1'b0);
    drive(16'h7FFF, 16'h8000, 1'b1);
    for (int i = 0; i < 600; i++) begin
      drive(DW'($urandom), DW'($urandom), 1'($urandom));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule